// File: doc/BRIEF.md
# Run-Time Sized Ring Pointer Controller

This block keeps the producer and consumer pointers of a circular queue that lives in system memory, for example the command ring or event ring of an I/O address-translation unit. Software programs a 64-bit ring base and a log2 ring size at run time; the block then advances each pointer on a single-cycle increment pulse. It reports when the ring is full or empty, and gives the byte address of the slot each pointer currently names. Each pointer carries a slot index in its low bits and a wrap flag in the bit just above the index, so a full ring and an empty ring can be told apart without a separate count.

The consumer register also holds a 7-bit command-error code above the pointer. Pointer movement never touches this code. Software may load either pointer directly, and may set the error code on its own or together with the consumer pointer. Fetching entries, decoding commands and raising interrupts belong to the surrounding logic.

Top module: `circq_ptr_ctrl`

## Requirements
- R1: After reset, both pointers, the error code, the log2 size and the base are zero, `ring_empty` is 1 and `ring_full` is 0.
- R2: A size write stores min(`size_wdata`, 19) as the log2 size and clears both pointers to zero in the same edge. The error code is kept.
- R3: An accepted producer increment sets PROD to (PROD+1) mod 2^(L+1), where L is the log2 size. Bit L is the wrap flag and toggles each time the index in bits [L-1:0] rolls over. The consumer pointer advances the same way.
- R4: `ring_full` is 1 exactly when the index bits of the two pointers are equal and their wrap bits differ. `ring_empty` is 1 exactly when all L+1 bits are equal.
- R5: A producer increment has no effect while the ring is full, and a consumer increment has no effect while it is empty. With `ring_en` low, both increments have no effect.
- R6: A consumer increment leaves the error code unchanged. The error code reads back in bits [30:24] of `cons_view`. A pulse on `err_we` loads `err_wdata` into the code: 0 none, 1 illegal command, 2 abort, 3 invalidation-sync failure.
- R7: Software pointer writes are masked to L+1 bits. A consumer write also loads the error code from `cons_werr`. A size write takes priority over a pointer write, and a pointer write takes priority over an increment in the same cycle. `cons_we` takes priority over `err_we`.
- R8: `prod_addr` and `cons_addr` equal (base AND 0x0000_FFFF_FFFF_FFE0) + ENTRY_BYTES × (pointer mod 2^L), where ENTRY_BYTES defaults to 16. Both addresses follow the registers with no added delay.
- R9: When producer and consumer increments arrive in the same cycle, each is accepted or refused on the pre-edge full and empty state, and both accepted moves take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_en | input | 1 | Ring enable; increments are ignored when low |
| base_we | input | 1 | Load the ring base |
| base_wdata | input | 64 | New ring base |
| size_we | input | 1 | Load the log2 size and clear both pointers |
| size_wdata | input | 5 | Requested log2 size |
| prod_we | input | 1 | Software load of PROD |
| prod_wdata | input | 20 | New PROD value |
| cons_we | input | 1 | Software load of CONS pointer and error code |
| cons_wdata | input | 20 | New CONS pointer |
| cons_werr | input | 7 | Error code loaded with `cons_we` |
| err_we | input | 1 | Load the error code only |
| err_wdata | input | 7 | New error code |
| prod_inc | input | 1 | Producer increment pulse |
| cons_inc | input | 1 | Consumer increment pulse |
| prod_view | output | 32 | PROD pointer, zero-extended |
| cons_view | output | 32 | Error code in [30:24], CONS pointer in the low bits |
| size_view | output | 5 | Current log2 size |
| ring_full | output | 1 | Ring full flag |
| ring_empty | output | 1 | Ring empty flag |
| prod_addr | output | 64 | Byte address of the producer slot |
| cons_addr | output | 64 | Byte address of the consumer slot |

## Verification
Producer and consumer increments can fall in the same cycle. This matters most at the edges, where the ring is full or empty and only one of the two moves may be accepted. The bench sends both pulses together while the ring is full, while it is empty and while it is partly filled, for ring sizes of 1 to 8 slots, and also through a long pseudo-random stream. After every edge it compares each pointer, both flags and both addresses with an arithmetic model that judges each pulse on the pre-edge state.

// File: rtl/circq_pkg.sv
package circq_pkg;

    localparam int CMD_ENTRY_BYTES = 16;
    localparam int EVT_ENTRY_BYTES = 32;
    localparam int RING_MAX_LOG2   = 19;

    typedef enum logic [6:0] {
        CERR_NONE     = 7'd0,
        CERR_ILLEGAL  = 7'd1,
        CERR_ABORT    = 7'd2,
        CERR_SYNC_INV = 7'd3
    } cmd_err_e;

endpackage

// File: rtl/circq_ptr.sv
module circq_ptr #(
    parameter int PTR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_val,
    input  logic             step,
    input  logic [PTR_W-1:0] wmask,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (wr_en) begin
            ptr <= wr_val & wmask;
        end else if (step) begin
            ptr <= (ptr + PTR_W'(1)) & wmask;
        end
    end

    // pointer never carries bits above the wrap flag
    assert_ptr_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr & ~wmask) == '0);

    // accepted step moves by exactly one modulo the ring span
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !wr_en) |=> ptr == (($past(ptr) + PTR_W'(1)) & $past(wmask)));

endmodule

// File: rtl/circq_addr.sv
module circq_addr #(
    parameter int ADDR_W      = 64,
    parameter int PA_W        = 48,
    parameter int ALIGN_BITS  = 5,
    parameter int ENTRY_BYTES = 16,
    parameter int PTR_W       = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  idx_mask,
    output logic [ADDR_W-1:0] addr
);

    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam logic [ADDR_W-1:0] HI_KEEP  = (ADDR_W'(1) << PA_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LO_DROP  = (ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] BASE_MSK = HI_KEEP & ~LO_DROP;

    logic [ADDR_W-1:0] slot_off;

    always_comb begin
        slot_off = ADDR_W'(ptr & idx_mask) << ENTRY_SHIFT;
        addr     = (base & BASE_MSK) + slot_off;
    end

endmodule

// File: rtl/circq_ptr_ctrl.sv
module circq_ptr_ctrl #(
    parameter int ADDR_W      = 64,
    parameter int PA_W        = 48,
    parameter int MAX_LOG2    = circq_pkg::RING_MAX_LOG2,
    parameter int ENTRY_BYTES = circq_pkg::CMD_ENTRY_BYTES,
    parameter int ERR_LSB     = 24,
    parameter int ERR_W       = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ring_en,
    input  logic                            base_we,
    input  logic [ADDR_W-1:0]               base_wdata,
    input  logic                            size_we,
    input  logic [$clog2(MAX_LOG2+1)-1:0]   size_wdata,
    input  logic                            prod_we,
    input  logic [MAX_LOG2:0]               prod_wdata,
    input  logic                            cons_we,
    input  logic [MAX_LOG2:0]               cons_wdata,
    input  logic [ERR_W-1:0]                cons_werr,
    input  logic                            err_we,
    input  logic [ERR_W-1:0]                err_wdata,
    input  logic                            prod_inc,
    input  logic                            cons_inc,
    output logic [31:0]                     prod_view,
    output logic [31:0]                     cons_view,
    output logic [$clog2(MAX_LOG2+1)-1:0]   size_view,
    output logic                            ring_full,
    output logic                            ring_empty,
    output logic [ADDR_W-1:0]               prod_addr,
    output logic [ADDR_W-1:0]               cons_addr
);

    localparam int PTR_W  = MAX_LOG2 + 1;
    localparam int LOG2_W = $clog2(MAX_LOG2 + 1);

    logic [ADDR_W-1:0] base_q;
    logic [LOG2_W-1:0] lg_q;
    logic [ERR_W-1:0]  err_q;
    logic [PTR_W-1:0]  prod_q, cons_q;
    logic [PTR_W:0]    one_sh;
    logic [PTR_W-1:0]  wrap_bit, idx_mask, wmask, diff;
    logic [LOG2_W-1:0] lg_clamped;
    logic              prod_go, cons_go;

    always_comb begin
        one_sh     = (PTR_W+1)'(1) << lg_q;
        wrap_bit   = one_sh[PTR_W-1:0];
        idx_mask   = wrap_bit - PTR_W'(1);
        wmask      = wrap_bit | idx_mask;
        diff       = (prod_q ^ cons_q) & wmask;
        ring_full  = (diff == wrap_bit);
        ring_empty = (diff == '0);
        prod_go    = ring_en && prod_inc && !ring_full;
        cons_go    = ring_en && cons_inc && !ring_empty;
        lg_clamped = (int'(size_wdata) > MAX_LOG2) ? LOG2_W'(MAX_LOG2) : size_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            lg_q   <= '0;
            err_q  <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (size_we) lg_q   <= lg_clamped;
            if (cons_we)     err_q <= cons_werr;
            else if (err_we) err_q <= err_wdata;
        end
    end

    circq_ptr #(.PTR_W(PTR_W)) u_prod (
        .clk(clk), .rst_n(rst_n), .clr(size_we), .wr_en(prod_we),
        .wr_val(prod_wdata), .step(prod_go), .wmask(wmask), .ptr(prod_q)
    );

    circq_ptr #(.PTR_W(PTR_W)) u_cons (
        .clk(clk), .rst_n(rst_n), .clr(size_we), .wr_en(cons_we),
        .wr_val(cons_wdata), .step(cons_go), .wmask(wmask), .ptr(cons_q)
    );

    circq_addr #(.ADDR_W(ADDR_W), .PA_W(PA_W), .ALIGN_BITS(5),
                 .ENTRY_BYTES(ENTRY_BYTES), .PTR_W(PTR_W)) u_paddr (
        .base(base_q), .ptr(prod_q), .idx_mask(idx_mask), .addr(prod_addr)
    );

    circq_addr #(.ADDR_W(ADDR_W), .PA_W(PA_W), .ALIGN_BITS(5),
                 .ENTRY_BYTES(ENTRY_BYTES), .PTR_W(PTR_W)) u_caddr (
        .base(base_q), .ptr(cons_q), .idx_mask(idx_mask), .addr(cons_addr)
    );

    always_comb begin
        prod_view = 32'(prod_q);
        cons_view = 32'(cons_q);
        cons_view[ERR_LSB +: ERR_W] = err_q;
        size_view = lg_q;
    end

    assert_size_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lg_q) <= MAX_LOG2);

    assert_resize_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        size_we |=> (prod_q == '0) && (cons_q == '0));

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_full && ring_empty));

    assert_full_blocks_prod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_full && !prod_we && !size_we) |=> $stable(prod_q));

    assert_empty_blocks_cons_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_empty && !cons_we && !size_we) |=> $stable(cons_q));

    assert_disabled_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_en && !prod_we && !cons_we && !size_we) |=> ($stable(prod_q) && $stable(cons_q)));

    assert_err_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cons_we && !err_we) |=> $stable(err_q));

endmodule

// File: tb/circq_ptr_ctrl_test.sv
module circq_ptr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ring_en, base_we, size_we, prod_we, cons_we, err_we, prod_inc, cons_inc;
    logic [63:0] base_wdata;
    logic [4:0]  size_wdata;
    logic [19:0] prod_wdata, cons_wdata;
    logic [6:0]  cons_werr, err_wdata;
    logic [31:0] prod_view, cons_view;
    logic [4:0]  size_view;
    logic        ring_full, ring_empty;
    logic [63:0] prod_addr, cons_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    longint unsigned m_base = 0;
    int unsigned m_lg = 0, m_p = 0, m_c = 0, m_err = 0;

    always #4 clk = ~clk;

    circq_ptr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ring_en(ring_en),
        .base_we(base_we), .base_wdata(base_wdata),
        .size_we(size_we), .size_wdata(size_wdata),
        .prod_we(prod_we), .prod_wdata(prod_wdata),
        .cons_we(cons_we), .cons_wdata(cons_wdata), .cons_werr(cons_werr),
        .err_we(err_we), .err_wdata(err_wdata),
        .prod_inc(prod_inc), .cons_inc(cons_inc),
        .prod_view(prod_view), .cons_view(cons_view), .size_view(size_view),
        .ring_full(ring_full), .ring_empty(ring_empty),
        .prod_addr(prod_addr), .cons_addr(cons_addr)
    );

    task automatic chk(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        base_we = 0; size_we = 0; prod_we = 0; cons_we = 0; err_we = 0;
        prod_inc = 0; cons_inc = 0;
    endtask

    function automatic bit m_full();
        int unsigned wm = (2 << m_lg) - 1;
        return ((m_p ^ m_c) & wm) == (1 << m_lg);
    endfunction

    function automatic bit m_empty();
        int unsigned wm = (2 << m_lg) - 1;
        return ((m_p ^ m_c) & wm) == 0;
    endfunction

    task automatic compare_all();
        longint unsigned bm = m_base & 64'h0000_FFFF_FFFF_FFE0;
        int unsigned im = (1 << m_lg) - 1;
        chk("R3 prod pointer", prod_view, m_p);
        chk("R6 cons view", cons_view, (m_err << 24) | m_c);
        chk("R2 size", size_view, m_lg);
        chk("R4 full flag", ring_full, m_full());
        chk("R4 empty flag", ring_empty, m_empty());
        chk("R8 prod addr", prod_addr, bm + 16 * (m_p & im));
        chk("R8 cons addr", cons_addr, bm + 16 * (m_c & im));
    endtask

    // apply current inputs for one edge, advance the model, compare
    task automatic step();
        int unsigned wm = (2 << m_lg) - 1;
        bit f = m_full(), e = m_empty();
        int unsigned np, nc, ne, nl;
        longint unsigned nb;
        np = m_p; nc = m_c; ne = m_err; nl = m_lg; nb = m_base;
        if (size_we) begin
            np = 0; nc = 0;
            nl = (size_wdata > 19) ? 19 : size_wdata;
        end else begin
            if (prod_we) np = prod_wdata & wm;
            else if (ring_en && prod_inc && !f) np = (m_p + 1) & wm;
            if (cons_we) nc = cons_wdata & wm;
            else if (ring_en && cons_inc && !e) nc = (m_c + 1) & wm;
        end
        if (cons_we) ne = cons_werr;
        else if (err_we) ne = err_wdata;
        if (base_we) nb = base_wdata;
        @(posedge clk);
        @(negedge clk);
        m_p = np; m_c = nc; m_err = ne; m_lg = nl; m_base = nb;
        compare_all();
        idle_inputs();
    endtask

    task automatic set_size(int unsigned v);
        size_we = 1; size_wdata = 5'(v); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 0; ring_en = 0; idle_inputs();
        base_wdata = '0; size_wdata = '0; prod_wdata = '0; cons_wdata = '0;
        cons_werr = '0; err_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 prod reset", prod_view, 0);
        chk("R1 cons reset", cons_view, 0);
        chk("R1 size reset", size_view, 0);
        chk("R1 empty reset", ring_empty, 1);
        chk("R1 full reset", ring_full, 0);
        chk("R1 addr reset", prod_addr, 0);

        ring_en = 1;
        base_we = 1; base_wdata = 64'hABCD_1234_5678_9ABF; step();
        chk("R8 masked base", cons_addr, 64'h0000_1234_5678_9AA0);

        // R2 clamp and clear
        set_size(25);
        chk("R2 clamp to 19", size_view, 19);
        prod_we = 1; prod_wdata = 20'hFFFFF; step();
        chk("R7 full-width write", prod_view, 32'hFFFFF);
        err_we = 1; err_wdata = 7'd2; step();
        set_size(2);
        chk("R2 resize clears prod", prod_view, 0);
        chk("R2 resize keeps err", cons_view[30:24], 2);

        // R4/R5 fill a 4-slot ring
        for (int i = 0; i < 4; i++) begin prod_inc = 1; step(); end
        chk("R4 full after 4", ring_full, 1);
        chk("R3 wrap bit set", prod_view, 4);
        prod_inc = 1; step();
        chk("R5 prod blocked when full", prod_view, 4);
        // R9 both while full: only cons moves
        prod_inc = 1; cons_inc = 1; step();
        chk("R9 full both prod", prod_view, 4);
        chk("R9 full both cons", cons_view[19:0], 1);
        // R9 both while partial: both move
        prod_inc = 1; cons_inc = 1; step();
        chk("R9 partial both prod", prod_view, 5);
        chk("R9 partial both cons", cons_view[19:0], 2);
        // R6 err kept across cons increments
        cons_inc = 1; step();
        chk("R6 err kept", cons_view[30:24], 2);
        // R7 masked cons write with error code
        cons_we = 1; cons_wdata = 20'hFFFFF; cons_werr = 7'd1; err_we = 1; err_wdata = 7'd3; step();
        chk("R7 cons masked", cons_view[19:0], 7);
        chk("R7 cons_we beats err_we", cons_view[30:24], 1);
        // R7 write beats increment
        prod_we = 1; prod_wdata = 20'd6; prod_inc = 1; step();
        chk("R7 write over inc", prod_view, 6);
        // R5 disabled
        ring_en = 0; prod_inc = 1; cons_inc = 1; step();
        chk("R5 disabled prod", prod_view, 6);
        chk("R5 disabled cons", cons_view[19:0], 7);
        ring_en = 1;
        // R5 empty: align pointers then cons_inc
        prod_we = 1; prod_wdata = 20'd7; step();
        chk("R4 empty equal", ring_empty, 1);
        cons_inc = 1; prod_inc = 0; step();
        chk("R5 cons blocked when empty", cons_view[19:0], 7);
        prod_inc = 1; cons_inc = 1; step();
        chk("R9 empty both prod", prod_view, 0);
        chk("R9 empty both cons", cons_view[19:0], 7);

        // sweep small ring sizes with a pseudo-random stream
        lfsr = 16'hACE1;
        for (int lg = 0; lg < 4; lg++) begin
            set_size(lg);
            for (int n = 0; n < 80; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ring_en  = !(lfsr[3] && lfsr[4] && lfsr[9]);
                prod_inc = lfsr[0] | lfsr[1];
                cons_inc = lfsr[2] | lfsr[11];
                prod_we  = (lfsr[7:5] == 3'd0);
                prod_wdata = {4'h0, lfsr};
                cons_we  = (lfsr[10:8] == 3'd7);
                cons_wdata = {4'h0, lfsr[7:0], lfsr[15:8]};
                cons_werr = 7'(lfsr[14:12]);
                err_we   = (lfsr[13:11] == 3'd0);
                err_wdata = 7'(lfsr[1:0]);
                step();
            end
        end
        ring_en = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule